// File: doc/BRIEF.md
# Two-Dimensional Event Address Sender

This block holds one pending-event flag per pixel of a square grid and sends the location of each pending pixel, one at a time, to a receiver. The location goes out as a row address and a column address, under a four-phase request/acknowledge handshake. Selection happens in two steps. A row picker first chooses one row among the rows that hold any pending flag, and the row address becomes valid. A column picker then chooses one pending pixel inside that row only, and the column address becomes valid. Because the two steps run in sequence, the block never pairs the row of one pixel with the column of another.

When the receiver acknowledges, the chosen pixel's flag is cleared by the coincidence of its row and column selection. Once that pixel no longer requests and the acknowledge is high, the whole selection state returns to its empty condition. The request is then withdrawn, and the cycle ends when the acknowledge falls.

Events are one-cycle pulses on a flat input vector. They are captured into the flags at any time, including during a transfer. An event on a pixel whose flag is already set adds nothing, because a pixel is either pending or not.

Top module: `aer_grid_sender`

## Requirements
- R1: After reset `req_o` is low, both address outputs are zero, all flags are clear, and no request appears until an event arrives.
- R2: A one-cycle high on `pix_evt_i` bit `r*COLS+c` marks pixel (row r, column c) pending. That pixel is later sent exactly once, with `addr_y_o`=r and `addr_x_o`=c.
- R3: Among rows with at least one pending pixel, the lowest row index is selected.
- R4: The column is chosen only among the pending pixels of the selected row, lowest column index first. No emitted (row, column) pair lacks a pending flag.
- R5: `req_o` rises only once both address halves are latched. Both addresses stay stable for as long as `req_o` is high.
- R6: `req_o` stays high until `ack_i` is high. The sent pixel's flag is then cleared and `req_o` falls. `req_o` does not rise again while `ack_i` stays high.
- R7: After every transfer the whole selection state is emptied and both address outputs return to zero. The next selection re-arbitrates over all rows and does not favour the previous row.
- R8: Events arriving during a transfer are captured and served in a later transfer. A repeated event on a pixel that is already pending has no further effect.
- R9: An event on the pixel being cleared, in the same cycle as its clear, is discarded. An event on any other pixel in that cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_evt_i | input | ROWS*COLS | Per-pixel event pulses, bit r*COLS+c for row r, column c |
| ack_i | input | 1 | Acknowledge from the receiver |
| req_o | output | 1 | Request to the receiver; address complete and stable while high |
| addr_y_o | output | log2(ROWS) | Row address of the selected pixel |
| addr_x_o | output | log2(COLS) | Column address of the selected pixel |

## Verification
The clear of the transmitted pixel and a fresh event on that same pixel can fall on the same clock edge. The bench provokes this by raising the acknowledge and pulsing that pixel's event together with an event on a second pixel, in the same cycle. It judges the outcome by checking that only the second pixel is sent afterwards and that the request then stays low. Row selection and event capture also coincide: events injected while an address is on the bus must leave that address unchanged and be served later in priority order.

// File: rtl/aer_pkg.sv
package aer_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ROW  = 3'd1,
    S_COL  = 3'd2,
    S_HOLD = 3'd3,
    S_DROP = 3'd4
  } arb_state_t;

endpackage

// File: rtl/aer_prio_pick.sv
module aer_prio_pick #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/aer_flag_row.sv
module aer_flag_row #(
  parameter int COLS = 64,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [COLS-1:0] evt_i,
  input  logic            clr_en_i,
  input  logic [CW-1:0]   clr_col_i,
  output logic [COLS-1:0] flags_o,
  output logic            any_o
);

  logic [COLS-1:0] flags_q;
  logic [COLS-1:0] flags_d;
  logic [COLS-1:0] clr_mask;
  logic            upd_en;

  always_comb begin
    clr_mask = '0;
    if (clr_en_i) clr_mask[clr_col_i] = 1'b1;
    // a clear beats a same-cycle event on the same pixel
    flags_d = (flags_q | evt_i) & ~clr_mask;
    upd_en  = (|evt_i) | clr_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;
  assign any_o   = |flags_q;

  // R9
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> !flags_q[$past(clr_col_i)]);

endmodule

// File: rtl/aer_grid_sender.sv
module aer_grid_sender #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ROWS*COLS-1:0] pix_evt_i,
  input  logic                 ack_i,
  output logic                 req_o,
  output logic [RW-1:0]        addr_y_o,
  output logic [CW-1:0]        addr_x_o
);
  import aer_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  arb_state_t      state_q, state_d;
  logic [RW-1:0]   row_q, row_d;
  logic [CW-1:0]   col_q, col_d;
  logic            clr_pulse;
  logic            fsm_en;

  logic [COLS-1:0] row_flags [ROWS];
  logic [ROWS-1:0] row_any;
  logic [COLS-1:0] sel_flags;
  logic            sel_flag;
  logic            row_hit, col_hit;
  logic [RW-1:0]   row_pick;
  logic [CW-1:0]   col_pick;

  // flag storage, one row per instance; clear by row select AND column select
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    aer_flag_row #(.COLS(COLS)) u_row (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .evt_i     (pix_evt_i[g*COLS +: COLS]),
      .clr_en_i  (clr_pulse && (row_q == RW'(g))),
      .clr_col_i (col_q),
      .flags_o   (row_flags[g]),
      .any_o     (row_any[g])
    );
  end

  assign sel_flags = row_flags[row_q];
  assign sel_flag  = sel_flags[col_q];

  aer_prio_pick #(.N(ROWS)) u_row_pick (
    .req_i (row_any),
    .any_o (row_hit),
    .idx_o (row_pick)
  );

  // only the selected row feeds the column picker
  aer_prio_pick #(.N(COLS)) u_col_pick (
    .req_i (sel_flags),
    .any_o (col_hit),
    .idx_o (col_pick)
  );

  always_comb begin
    state_d   = state_q;
    row_d     = row_q;
    col_d     = col_q;
    clr_pulse = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (row_hit) begin
          row_d   = row_pick;
          state_d = S_ROW;
        end
      end
      S_ROW: begin
        if (col_hit) begin
          col_d   = col_pick;
          state_d = S_COL;
        end else begin
          row_d   = '0;
          state_d = S_IDLE;
        end
      end
      S_COL: begin
        if (ack_i) begin
          clr_pulse = 1'b1;
          state_d   = S_HOLD;
        end
      end
      S_HOLD: begin
        // full reset once the pixel no longer requests and ack is high
        if (ack_i && !sel_flag) begin
          row_d   = '0;
          col_d   = '0;
          state_d = S_DROP;
        end
      end
      S_DROP: begin
        if (!ack_i) state_d = S_IDLE;
      end
      default: begin
        row_d   = '0;
        col_d   = '0;
        state_d = S_IDLE;
      end
    endcase
    fsm_en = (state_d != state_q);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else if (fsm_en) begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end

  assign req_o    = (state_q == S_COL) || (state_q == S_HOLD);
  assign addr_y_o = row_q;
  assign addr_x_o = col_q;

  // R3
  row_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == S_ROW) |-> row_any[row_q]);

  // R4
  col_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == S_COL) |-> sel_flags[col_q]);

  // R5
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_o && $past(req_o)) |-> ($stable(addr_y_o) && $stable(addr_x_o)));

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o);

  // R6
  no_rerise_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!req_o && ack_i) |=> !req_o);

  // R7
  idle_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (row_q == '0 && col_q == '0));

endmodule

// File: tb/aer_grid_sender_test.sv
module aer_grid_sender_test;

  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  logic                 clk;
  logic                 rst_n;
  logic [ROWS*COLS-1:0] pix_evt;
  logic                 ack;
  logic                 req;
  logic [RW-1:0]        addr_y;
  logic [CW-1:0]        addr_x;

  logic [ROWS*COLS-1:0] pend;
  logic [ROWS*COLS-1:0] stage;

  int checks = 0;
  int errors = 0;

  aer_grid_sender #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pix_evt_i (pix_evt),
    .ack_i     (ack),
    .req_o     (req),
    .addr_y_o  (addr_y),
    .addr_x_o  (addr_x)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic add(input int r, input int c);
    stage[r*COLS+c] = 1'b1;
  endtask

  // drive staged events for one cycle
  task automatic fire();
    @(negedge clk);
    pix_evt = stage;
    pend    = pend | stage;
    @(negedge clk);
    pix_evt = '0;
    stage   = '0;
  endtask

  task automatic wait_req(input string rq, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (req) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk(ok, rq, int'(req), 1);
  endtask

  task automatic wait_drop(input string rq);
    bit ok = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!req) begin ok = 1'b1; break; end
    end
    chk(ok, rq, int'(req), 0);
  endtask

  task automatic check_addr(input int r, input int c, input string rq);
    chk(int'(addr_y) == r, rq, int'(addr_y), r);
    chk(int'(addr_x) == c, rq, int'(addr_x), c);
    // R4: emitted pair must be pending
    chk(pend[int'(addr_y)*COLS+int'(addr_x)] == 1'b1, "R4 ghost",
        int'(addr_y)*COLS+int'(addr_x), r*COLS+c);
  endtask

  // one full transfer, with optional events injected while the address is up
  task automatic serve(input int r, input int c, input string rq,
                       input bit inj = 1'b0);
    bit ok;
    wait_req(rq, ok);
    if (!ok) return;
    check_addr(r, c, rq);
    if (inj) begin
      pix_evt = stage;
      pend    = pend | stage;
      @(negedge clk);
      pix_evt = '0;
      stage   = '0;
      chk(req == 1'b1 && int'(addr_y) == r && int'(addr_x) == c, "R5 stable during inject",
          int'(addr_y)*COLS+int'(addr_x), r*COLS+c);
    end
    pend[r*COLS+c] = 1'b0;
    ack = 1'b1;
    wait_drop("R6 drop");
    ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_quiet(input int n, input string rq);
    bit quiet = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req) quiet = 1'b0;
    end
    chk(quiet, rq, int'(!quiet), 0);
  endtask

  task automatic t_reset();
    chk(req == 1'b0, "R1 req", int'(req), 0);
    chk(addr_y == '0 && addr_x == '0, "R1 addr", int'(addr_y)*COLS+int'(addr_x), 0);
    expect_quiet(10, "R1 quiet");
  endtask

  task automatic t_single();
    add(5, 9); fire();
    serve(5, 9, "R2 single");
    // R7: selection state emptied after the transfer
    chk(addr_y == '0 && addr_x == '0, "R7 addr cleared", int'(addr_y)*COLS+int'(addr_x), 0);
    expect_quiet(10, "R2 once");
  endtask

  task automatic t_row_prio();
    add(7, 3); add(2, 40); fire();
    serve(2, 40, "R3 lowest row");
    serve(7, 3, "R4 no ghost");
    expect_quiet(5, "R2 drained");
  endtask

  task automatic t_col_prio();
    add(10, 20); add(10, 4); add(11, 0); fire();
    serve(10, 4, "R4 lowest col");
    serve(10, 20, "R4 same row next");
    serve(11, 0, "R3 next row");
  endtask

  task automatic t_inflight();
    add(30, 1); fire();
    add(3, 3); add(30, 5);
    serve(30, 1, "R8 inflight", 1'b1);
    serve(3, 3, "R7 rearbitrate");
    serve(30, 5, "R8 later");
    expect_quiet(5, "R8 drained");
  endtask

  task automatic t_dup();
    add(12, 12); fire();
    add(12, 12); fire();
    serve(12, 12, "R8 dup");
    expect_quiet(20, "R8 single send");
  endtask

  task automatic t_collide();
    bit ok;
    add(20, 20); fire();
    wait_req("R9 req", ok);
    if (ok) begin
      check_addr(20, 20, "R9 addr");
      pend[20*COLS+20] = 1'b0;
      ack = 1'b1;
      pix_evt[20*COLS+20] = 1'b1;
      pix_evt[21*COLS+7]  = 1'b1;
      pend[21*COLS+7]     = 1'b1;
      @(negedge clk);
      pix_evt = '0;
      wait_drop("R9 drop");
      ack = 1'b0;
      @(negedge clk);
    end
    serve(21, 7, "R9 other kept");
    expect_quiet(20, "R9 same pixel discarded");
  endtask

  task automatic t_slow();
    bit ok;
    bit held = 1'b1;
    bit low  = 1'b1;
    add(40, 2); add(41, 2); fire();
    wait_req("R6 slow req", ok);
    if (ok) begin
      check_addr(40, 2, "R5 slow addr");
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (!req || int'(addr_y) != 40 || int'(addr_x) != 2) held = 1'b0;
      end
      chk(held, "R6 hold without ack", int'(req), 1);
      pend[40*COLS+2] = 1'b0;
      ack = 1'b1;
      wait_drop("R6 slow drop");
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (req) low = 1'b0;
      end
      chk(low, "R6 no rise while ack", int'(!low), 0);
      ack = 1'b0;
      @(negedge clk);
    end
    serve(41, 2, "R6 after release");
  endtask

  task automatic t_corner();
    add(63, 63); add(63, 0); add(0, 63); fire();
    serve(0, 63, "R2 corner top");
    serve(63, 0, "R3 corner last row");
    serve(63, 63, "R2 corner far");
    expect_quiet(5, "R2 corner drained");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    ack     = 1'b0;
    pix_evt = '0;
    pend    = '0;
    stage   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_row_prio();
    t_col_prio();
    t_inflight();
    t_dup();
    t_collide();
    t_slow();
    t_corner();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule